// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block produces the serial clock of an I2C master. It holds two pairs of programmable phase counts, one pair for standard speed and one for fast speed, plus a small control word that sets master operation and picks the speed. While the controller is enabled and a run request is present, the block alternates between pulling the open-drain clock line low and releasing it. It times each phase in reference clock cycles and adds a fixed number of overhead cycles to each programmed count.

The low phase is timed from the cycle in which the block starts pulling the line. After the release, the block waits until it actually samples the line high. A target that keeps the line low therefore stretches the clock, and the high-phase timer does not start until the line is seen high. Two single-cycle strobes tell a neighbouring data engine when to present the next bit and when to capture the line.

Top module: `scl_timing_gen`

## Requirements
- R1: After a synchronous reset, the line is released and neither strobe is asserted.
- R2: The control word is written at address 0. Bit 0 set means master operation, and bits 2:1 hold the speed: 1 is standard and 2 is fast. With bit 0 clear, or with a speed value of 0 or 3, the line is never pulled low.
- R3: Each low phase holds the line low for exactly the low count plus 1 reference cycles, timed from the first cycle of pulling low.
- R4: The high phase lasts the high count plus 8 cycles. It is timed from the first released cycle in which the line is sampled high and ends when the block pulls low again.
- R5: While the line stays low after the release, the high timer does not advance. The released interval grows by exactly the number of held-low cycles.
- R6: Speed 1 uses the standard counts, written at address 1 (high) and address 2 (low). Speed 2 uses the fast counts, written at address 3 (high) and address 4 (low).
- R7: A configuration write that arrives while the controller is enabled is ignored.
- R8: `shift_o` is high for one cycle, in the first cycle of each low phase, and at no other time.
- R9: `sample_o` is high for one cycle per high phase, at index (high count + 8)/2 rounded down. Index 0 is the first cycle in which the line is seen high.
- R10: If the run request is low when a high phase ends, the block stays released and idle. If the enable is dropped, the line is released in the next cycle.
- R11: From idle, with the controller enabled, a valid control word and the run request present, the line is pulled low in the cycle after the request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller enable; configuration writes are accepted only while this is low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration address (0 control, 1/2 standard high/low, 3/4 fast high/low) |
| cfg_wdata_i | input | CNT_W | Configuration write data |
| run_i | input | 1 | Request to keep generating clock periods |
| scl_i | input | 1 | Sampled level of the clock line |
| scl_drive_o | output | 1 | 1 pulls the clock line low; 0 releases it |
| shift_o | output | 1 | One-cycle strobe at the start of a low phase |
| sample_o | output | 1 | One-cycle strobe at the middle of a high phase |

## Verification
The hardest case to reach is clock stretching. The block only ever sees the line level, so the test has to make the line stay low after the block has let go. The testbench models the wired line as the AND of the block's release and a target hold. It also models a target that keeps the line low for a chosen number of cycles after each release. This shows that the released interval and the sample strobe position both move by exactly that number of cycles.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_LOW       = 2'd1,
        PH_WAIT_HIGH = 2'd2,
        PH_HIGH      = 2'd3
    } scl_phase_e;

    typedef struct packed {
        logic [1:0] speed;
        logic       master;
    } scl_ctrl_t;

    localparam int HIGH_OVERHEAD = 8;
    localparam int LOW_OVERHEAD  = 1;

    localparam logic [1:0] SPEED_STD  = 2'd1;
    localparam logic [1:0] SPEED_FAST = 2'd2;

    localparam logic [2:0] ADDR_CTRL    = 3'd0;
    localparam logic [2:0] ADDR_STD_HI  = 3'd1;
    localparam logic [2:0] ADDR_STD_LO  = 3'd2;
    localparam logic [2:0] ADDR_FAST_HI = 3'd3;
    localparam logic [2:0] ADDR_FAST_LO = 3'd4;

    function automatic logic ctrl_runnable(scl_ctrl_t c);
        return c.master && (c.speed == SPEED_STD || c.speed == SPEED_FAST);
    endfunction

endpackage

// File: rtl/scl_timing_cfg.sv
module scl_timing_cfg
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int STD_HI_RST  = 40,
    parameter int STD_LO_RST  = 47,
    parameter int FAST_HI_RST = 6,
    parameter int FAST_LO_RST = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_addr_i,
    input  logic [CNT_W-1:0] cfg_wdata_i,
    output logic             runnable_o,
    output logic [CNT_W-1:0] hi_cnt_o,
    output logic [CNT_W-1:0] lo_cnt_o
);

    scl_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] std_hi_q, std_lo_q, fast_hi_q, fast_lo_q;
    logic             wr_ok;

    assign wr_ok = cfg_we_i && !enable_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            std_hi_q  <= CNT_W'(STD_HI_RST);
            std_lo_q  <= CNT_W'(STD_LO_RST);
            fast_hi_q <= CNT_W'(FAST_HI_RST);
            fast_lo_q <= CNT_W'(FAST_LO_RST);
        end else if (wr_ok) begin
            case (cfg_addr_i)
                ADDR_CTRL:    ctrl_q    <= scl_ctrl_t'(cfg_wdata_i[2:0]);
                ADDR_STD_HI:  std_hi_q  <= cfg_wdata_i;
                ADDR_STD_LO:  std_lo_q  <= cfg_wdata_i;
                ADDR_FAST_HI: fast_hi_q <= cfg_wdata_i;
                ADDR_FAST_LO: fast_lo_q <= cfg_wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        runnable_o = ctrl_runnable(ctrl_q);
        if (ctrl_q.speed == SPEED_FAST) begin
            hi_cnt_o = fast_hi_q;
            lo_cnt_o = fast_lo_q;
        end else begin
            hi_cnt_o = std_hi_q;
            lo_cnt_o = std_lo_q;
        end
    end

endmodule

// File: rtl/scl_phase_engine.sv
module scl_phase_engine
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             run_i,
    input  logic             scl_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    output logic             drive_o,
    output logic             shift_o,
    output logic             sample_o
);

    localparam int CW = CNT_W + 1;

    scl_phase_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   high_last;
    logic [CW-1:0]   high_mid;
    logic [CW-1:0]   low_last;

    assign high_last = {1'b0, hi_cnt_i} + CW'(HIGH_OVERHEAD - 1);
    assign high_mid  = ({1'b0, hi_cnt_i} + CW'(HIGH_OVERHEAD)) >> 1;
    assign low_last  = {1'b0, lo_cnt_i} + CW'(LOW_OVERHEAD - 1);

    always_ff @(posedge clk) begin
        if (rst || !go_i) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PH_IDLE: begin
                    if (run_i) begin
                        state_q <= PH_LOW;
                        cnt_q   <= '0;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == low_last) begin
                        state_q <= PH_WAIT_HIGH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WAIT_HIGH: begin
                    if (scl_i) begin
                        state_q <= PH_HIGH;
                        cnt_q   <= CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt_q >= high_last) begin
                        state_q <= run_i ? PH_LOW : PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign drive_o  = (state_q == PH_LOW);
    assign shift_o  = (state_q == PH_LOW) && (cnt_q == '0);
    assign sample_o = (state_q == PH_HIGH) && (cnt_q == high_mid);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_addr_i,
    input  logic [CNT_W-1:0] cfg_wdata_i,
    input  logic             run_i,
    input  logic             scl_i,
    output logic             scl_drive_o,
    output logic             shift_o,
    output logic             sample_o
);

    logic             runnable;
    logic [CNT_W-1:0] hi_cnt, lo_cnt;

    scl_timing_cfg #(.CNT_W(CNT_W)) cfg_i (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .runnable_o  (runnable),
        .hi_cnt_o    (hi_cnt),
        .lo_cnt_o    (lo_cnt)
    );

    scl_phase_engine #(.CNT_W(CNT_W)) eng_i (
        .clk      (clk),
        .rst      (rst),
        .go_i     (enable_i && runnable),
        .run_i    (run_i),
        .scl_i    (scl_i),
        .hi_cnt_i (hi_cnt),
        .lo_cnt_i (lo_cnt),
        .drive_o  (scl_drive_o),
        .shift_o  (shift_o),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic scl_i,
    input logic scl_drive_o,
    input logic shift_o,
    input logic sample_o
);

    AST_SHIFT_ON_PULL: assert property (@(posedge clk) disable iff (rst)
        (scl_drive_o && !$past(scl_drive_o)) |-> shift_o); // R8

    AST_SHIFT_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        shift_o |-> scl_drive_o); // R8

    AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        shift_o |=> !shift_o); // R8

    AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> (scl_i && !scl_drive_o)); // R9

    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o); // R9

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !scl_drive_o); // R10

endmodule

bind scl_timing_gen scl_timing_gen_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (enable_i),
    .scl_i       (scl_i),
    .scl_drive_o (scl_drive_o),
    .shift_o     (shift_o),
    .sample_o    (sample_o)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    localparam int CNT_W = 16;

    typedef struct {
        int lo;
        int rel;
        int samp;
    } period_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable_i = 1'b0;
    logic             cfg_we_i = 1'b0;
    logic [2:0]       cfg_addr_i = '0;
    logic [CNT_W-1:0] cfg_wdata_i = '0;
    logic             run_i = 1'b0;
    logic             scl_i;
    logic             scl_drive_o, shift_o, sample_o;

    int  n_checks = 0;
    int  n_errors = 0;
    int  stretch_len = 0;
    int  hold_cnt = 0;
    int  rise_cnt = 0;
    bit  first_flag = 1'b1;
    period_t exp_q[$];

    always #5 clk = ~clk;

    // wired line: released only if neither side holds it low
    assign scl_i = !(scl_drive_o || (hold_cnt > 0));

    always @(posedge clk) begin
        if (scl_drive_o) hold_cnt <= stretch_len;
        else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    end

    scl_timing_gen #(.CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .run_i       (run_i),
        .scl_i       (scl_i),
        .scl_drive_o (scl_drive_o),
        .shift_o     (shift_o),
        .sample_o    (sample_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measures each full period and compares against the queue
    bit prev_drive = 1'b0;
    bit have = 1'b0;
    int lo_meas = 0, rel_meas = 0, samp_meas = -1;

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_drive_o) begin
                if (!prev_drive) begin
                    rise_cnt++;
                    check(shift_o == 1'b1, "R8 shift at pull", int'(shift_o), 1);
                    if (first_flag) begin
                        first_flag = 1'b0;
                    end else if (have) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R10 unexpected period", 1, 0);
                        end else begin
                            period_t e;
                            e = exp_q.pop_front();
                            check(lo_meas == e.lo, "R3 low length", lo_meas, e.lo);
                            check(rel_meas == e.rel, "R4/R5 released length", rel_meas, e.rel);
                            check(samp_meas == e.samp, "R9 sample index", samp_meas, e.samp);
                        end
                    end
                    lo_meas = 1; rel_meas = 0; samp_meas = -1; have = 1'b0;
                end else begin
                    lo_meas++;
                    if (shift_o) check(1'b0, "R8 extra shift", 1, 0);
                end
                if (sample_o) check(1'b0, "R9 sample while low", 1, 0);
            end else begin
                if (prev_drive) have = 1'b1;
                if (shift_o) check(1'b0, "R8 shift while released", 1, 0);
                if (have) begin
                    if (sample_o) samp_meas = rel_meas;
                    rel_meas++;
                end
            end
            prev_drive = scl_drive_o;
        end
    end

    task automatic cfg_write(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = CNT_W'(d);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // driver: pushes expected periods, then runs the burst
    task automatic run_burst(input int n, input int s, input int lo, input int hi, input string req);
        int base;
        stretch_len = s;
        first_flag  = 1'b1;
        for (int i = 1; i < n; i++) begin
            period_t p;
            p.lo = lo + 1; p.rel = s + hi + 8; p.samp = s + (hi + 8) / 2;
            exp_q.push_back(p);
        end
        @(negedge clk);
        base  = rise_cnt;
        run_i = 1'b1;
        @(negedge clk);
        check(scl_drive_o == 1'b1, {req, " R11 start latency"}, int'(scl_drive_o), 1);
        wait (rise_cnt == base + n);
        @(negedge clk);
        run_i = 1'b0;
        repeat (lo + hi + s + 30) @(negedge clk);
        check(scl_drive_o == 1'b0, {req, " R10 idle after run drop"}, int'(scl_drive_o), 0);
        check(exp_q.size() == 0, {req, " R3 all periods seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        check(scl_drive_o == 1'b0, "R1 line released in reset", int'(scl_drive_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(scl_drive_o == 1'b0 && shift_o == 1'b0 && sample_o == 1'b0,
              "R1 reset outputs", int'({scl_drive_o, shift_o, sample_o}), 0);

        // standard pair, ideal line (R3 R4 R6 R9 R11)
        cfg_write(3'd1, 4);
        cfg_write(3'd2, 5);
        cfg_write(3'd3, 3);
        cfg_write(3'd4, 2);
        cfg_write(3'd0, 3'b011);
        enable_i = 1'b1;
        run_burst(4, 0, 5, 4, "R6 std");

        // writes while enabled are ignored (R7)
        cfg_write(3'd2, 20);
        cfg_write(3'd1, 30);
        cfg_write(3'd0, 3'b000);
        run_burst(3, 0, 5, 4, "R7 locked");

        // target stretches the clock (R5)
        run_burst(4, 5, 5, 4, "R5 stretch");

        // fast pair with odd high count (R2 R6 R9)
        enable_i = 1'b0;
        cfg_write(3'd0, 3'b101);
        enable_i = 1'b1;
        run_burst(4, 0, 2, 3, "R6 fast");

        // invalid speed value 3 and master clear: no clock (R2)
        enable_i = 1'b0;
        cfg_write(3'd0, 3'b111);
        enable_i = 1'b1;
        r0 = rise_cnt;
        run_i = 1'b1;
        repeat (40) @(negedge clk);
        check(rise_cnt == r0 && !scl_drive_o, "R2 speed 3 idle", rise_cnt - r0, 0);
        run_i = 1'b0;
        enable_i = 1'b0;
        cfg_write(3'd0, 3'b010);
        enable_i = 1'b1;
        run_i = 1'b1;
        repeat (40) @(negedge clk);
        check(rise_cnt == r0 && !scl_drive_o, "R2 master clear idle", rise_cnt - r0, 0);
        run_i = 1'b0;

        // disable during a low phase releases the line next cycle (R10)
        enable_i = 1'b0;
        cfg_write(3'd0, 3'b011);
        cfg_write(3'd2, 10);
        enable_i = 1'b1;
        stretch_len = 0;
        first_flag = 1'b1;
        @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        check(scl_drive_o == 1'b1, "R11 pull after request", int'(scl_drive_o), 1);
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        check(scl_drive_o == 1'b0, "R10 release on disable", int'(scl_drive_o), 0);
        run_i = 1'b0;
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule